// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block lets one processor hand a fixed-length message to another processor and raise an interrupt on the receiving side. Software reaches it through a simple register port that has a write strobe, a word address, write data and combinational read data. The block holds `NCH` channels. Each channel has its own 64-byte register window, eight message words and a small ownership state machine. Each bit of the interrupt vectors stands for one processor.

A global write lock protects every channel register, and only a key written to the lock register opens it. A sender claims an idle channel by writing its own one-hot bit, loads the message and destination set, and then fires the channel by writing its bit to the send register. This raises every destination bit that is selected and not masked. The acknowledge comes back to the sender in one of two ways. In automatic mode it returns at once. In manual mode it returns once the receiver clears its destination interrupt. The sender then clears the acknowledge, and the channel becomes ready for the next message.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the lock reads 1 (closed), every channel reports idle (mode read 0x10), and both interrupt vectors are zero.
- R2: Writing 0x1ACCE551 to the lock register at 0xA00 opens the lock, so that a read there returns 0. Any other value written there closes it, so that a read returns 1.
- R3: While the lock is closed, writes to channel registers change no channel state and no interrupt output. Reads still work.
- R4: Writing a nonzero value to the source register (offset 0x00) of an idle channel stores it and moves the channel to ready. The same write on a channel that is not idle leaves the source register unchanged.
- R5: Writing zero to the source register returns the channel to idle from any state and clears the source.
- R6: The eight message words sit at offsets 0x20 to 0x3C and read back as written. Channel n occupies addresses n*0x40 to n*0x40+0x3F. Reads outside the populated channels and the lock register return 0.
- R7: Writing the stored source bit to the send register (offset 0x1C) of a ready channel ORs (destination at 0x04) AND NOT (mask at 0x14) into the pending set. The pending set drives `irq_dst`. A send with any other value, or in any other state, does nothing.
- R8: When mode bit 0 (offset 0x10) is 1, a send moves the channel straight to the acknowledged state.
- R9: When mode bit 0 is 0, a send moves the channel to the sent state. The next write to destination clear (offset 0x08) moves it to the acknowledged state.
- R10: A destination clear write removes the written bits from the pending set. The destination status register (offset 0x0C) reads the pending set.
- R11: In the acknowledged state the source bit appears on `irq_ack`. Writing that bit to interrupt clear (offset 0x18) returns the channel to ready and drops it.
- R12: A mode read returns bit 7 acknowledged, bit 6 sent, bit 5 ready, bit 4 idle and bit 0 the automatic-acknowledge setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_dst | output | NIRQ | Destination interrupts, OR of all channels' pending sets |
| irq_ack | output | NIRQ | Acknowledge interrupts toward the senders |

## Verification
The bench goes after the ownership rules. It makes a second claim on a channel that is already owned, which a design missing the idle check would accept, overwriting the first owner. It sends with the wrong source bit, which a careless decoder would accept and so raise a spurious destination interrupt. It unmasks only one of two selected destinations, so a design that ignores the mask raises an extra `irq_dst` bit. It closes the lock with a wrong key and then tries to release the channel: a design that gates only some registers would lose ownership. Manual and automatic acknowledge are both run so that a state machine that skips or sticks in the sent state shows up at the mode read.

// File: rtl/ipc_mbox_pkg.sv
package ipc_mbox_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SENT  = 2'd2,
        ST_ACK   = 2'd3
    } ch_state_e;

    localparam int LOCK_ADDR = 'hA00;
    localparam logic [31:0] LOCK_KEY = 32'h1ACC_E551;

    // word indices inside a channel window
    localparam logic [3:0] W_SRC   = 4'd0;
    localparam logic [3:0] W_DST   = 4'd1;
    localparam logic [3:0] W_DCLR  = 4'd2;
    localparam logic [3:0] W_DSTAT = 4'd3;
    localparam logic [3:0] W_MODE  = 4'd4;
    localparam logic [3:0] W_MASK  = 4'd5;
    localparam logic [3:0] W_ICLR  = 4'd6;
    localparam logic [3:0] W_SEND  = 4'd7;
endpackage

// File: rtl/ipc_mbox_lock.sv
module ipc_mbox_lock (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_we,
    input  logic [31:0] wdata,
    output logic        locked
);
    import ipc_mbox_pkg::*;

    logic locked_d, locked_q;

    always_comb begin
        locked_d = locked_q;
        if (lock_we) begin
            locked_d = (wdata != LOCK_KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked_q <= 1'b1;
        else        locked_q <= locked_d;
    end

    assign locked = locked_q;
endmodule

// File: rtl/ipc_mbox_chan.sv
module ipc_mbox_chan #(
    parameter int NIRQ  = 8,
    parameter int NWORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [3:0]      widx,
    input  logic [31:0]     wdata,
    output logic [31:0]     rd,
    output logic [NIRQ-1:0] pend,
    output logic [NIRQ-1:0] ack
);
    import ipc_mbox_pkg::*;

    typedef struct packed {
        ch_state_e                 st;
        logic [NIRQ-1:0]           src;
        logic [NIRQ-1:0]           dst;
        logic [NIRQ-1:0]           mask;
        logic [NIRQ-1:0]           pend;
        logic                      auto_ack;
        logic [NWORD-1:0][31:0]    data;
    } chan_t;

    chan_t cur_q, nxt_d;
    logic [NIRQ-1:0] wbits;

    assign wbits = wdata[NIRQ-1:0];

    always_comb begin
        nxt_d = cur_q;
        if (we) begin
            case (widx)
                W_SRC: begin
                    if (wbits == '0) begin
                        nxt_d.src = '0;
                        nxt_d.st  = ST_IDLE;
                    end else if (cur_q.st == ST_IDLE) begin
                        nxt_d.src = wbits;
                        nxt_d.st  = ST_READY;
                    end
                end
                W_DST:  nxt_d.dst = wbits;
                W_DCLR: begin
                    nxt_d.pend = cur_q.pend & ~wbits;
                    if (cur_q.st == ST_SENT) nxt_d.st = ST_ACK;
                end
                W_MODE: nxt_d.auto_ack = wdata[0];
                W_MASK: nxt_d.mask = wbits;
                W_ICLR: begin
                    if (cur_q.st == ST_ACK && wbits == cur_q.src) nxt_d.st = ST_READY;
                end
                W_SEND: begin
                    if (cur_q.st == ST_READY && wbits == cur_q.src) begin
                        nxt_d.pend = cur_q.pend | (cur_q.dst & ~cur_q.mask);
                        nxt_d.st   = cur_q.auto_ack ? ST_ACK : ST_SENT;
                    end
                end
                default: begin
                    if (widx >= 4'd8) nxt_d.data[widx[2:0]] = wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q          <= '0;
            cur_q.st       <= ST_IDLE;
            cur_q.mask     <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        rd = '0;
        case (widx)
            W_SRC:   rd[NIRQ-1:0] = cur_q.src;
            W_DST:   rd[NIRQ-1:0] = cur_q.dst;
            W_DSTAT: rd[NIRQ-1:0] = cur_q.pend;
            W_MODE:  rd = {24'd0, cur_q.st == ST_ACK, cur_q.st == ST_SENT,
                           cur_q.st == ST_READY, cur_q.st == ST_IDLE, 3'd0, cur_q.auto_ack};
            W_MASK:  rd[NIRQ-1:0] = cur_q.mask;
            default: if (widx >= 4'd8) rd = cur_q.data[widx[2:0]];
        endcase
    end

    assign pend = cur_q.pend;
    assign ack  = (cur_q.st == ST_ACK) ? cur_q.src : '0;
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
    parameter int NCH  = 4,
    parameter int NIRQ = 8,
    parameter int AW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    output logic [NIRQ-1:0] irq_dst,
    output logic [NIRQ-1:0] irq_ack
);
    import ipc_mbox_pkg::*;

    localparam int CHW = AW - 6;

    logic                       locked;
    logic                       lock_hit;
    logic [NCH-1:0]             chan_sel;
    logic [NCH-1:0][31:0]       ch_rd;
    logic [NCH-1:0][NIRQ-1:0]   ch_pend;
    logic [NCH-1:0][NIRQ-1:0]   ch_ack;

    assign lock_hit = (addr == AW'(LOCK_ADDR));

    ipc_mbox_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock_we (wr_en && lock_hit),
        .wdata   (wdata),
        .locked  (locked)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign chan_sel[i] = (addr[AW-1:6] == CHW'(i));
        ipc_mbox_chan #(.NIRQ(NIRQ), .NWORD(8)) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && !locked && chan_sel[i]),
            .widx  (addr[5:2]),
            .wdata (wdata),
            .rd    (ch_rd[i]),
            .pend  (ch_pend[i]),
            .ack   (ch_ack[i])
        );
    end

    always_comb begin
        rdata   = '0;
        irq_dst = '0;
        irq_ack = '0;
        if (lock_hit) rdata = {31'd0, locked};
        for (int i = 0; i < NCH; i++) begin
            if (chan_sel[i]) rdata = ch_rd[i];
            irq_dst = irq_dst | ch_pend[i];
            irq_ack = irq_ack | ch_ack[i];
        end
    end
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk #(
    parameter int NCH  = 4,
    parameter int NIRQ = 8,
    parameter int AW   = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_en,
    input logic [AW-1:0]            addr,
    input logic [31:0]              wdata,
    input logic [NIRQ-1:0]          irq_dst,
    input logic [NIRQ-1:0]          irq_ack,
    input logic                     locked,
    input logic [NCH-1:0][NIRQ-1:0] ch_pend
);
    import ipc_mbox_pkg::*;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (locked && irq_dst == '0 && irq_ack == '0));

    a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(LOCK_ADDR) && wdata == LOCK_KEY) |=> !locked);

    a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(LOCK_ADDR) && wdata != LOCK_KEY) |=> locked);

    a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(irq_dst) && $stable(irq_ack)));

    a_r7_pend_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_pend));

    a_r10_dclr_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !locked && addr == AW'(8)) |=>
        ((ch_pend[0] & $past(wdata[NIRQ-1:0])) == '0));
endmodule

bind ipc_mailbox ipc_mailbox_chk #(.NCH(NCH), .NIRQ(NIRQ), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .irq_dst (irq_dst),
    .irq_ack (irq_ack),
    .locked  (locked),
    .ch_pend (ch_pend)
);

// File: tb/tb_ipc_mailbox.sv
module tb_ipc_mailbox;
    localparam int NCH = 4;
    localparam int NIRQ = 8;
    localparam int AW = 12;
    localparam int KEY = 32'h1ACCE551;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NIRQ-1:0] irq_dst, irq_ack;

    int n_chk = 0, n_fail = 0;
    bit running = 0;

    always #2 clk = ~clk;

    ipc_mailbox #(.NCH(NCH), .NIRQ(NIRQ), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_dst(irq_dst), .irq_ack(irq_ack));

    // reference model: 0 idle, 1 ready, 2 sent, 3 ack
    int m_lock;
    int m_st[NCH], m_src[NCH], m_dst[NCH], m_mask[NCH], m_pend[NCH], m_auto[NCH];
    int m_data[NCH][8];

    task automatic mdl_reset();
        m_lock = 1;
        for (int c = 0; c < NCH; c++) begin
            m_st[c] = 0; m_src[c] = 0; m_dst[c] = 0; m_mask[c] = 'hFF;
            m_pend[c] = 0; m_auto[c] = 0;
            for (int w = 0; w < 8; w++) m_data[c][w] = 0;
        end
    endtask

    task automatic mdl_write(int a, int d);
        int c, w, b;
        b = d & 'hFF;
        if (a == 'hA00) begin
            m_lock = (d != KEY) ? 1 : 0;
            return;
        end
        c = a / 64; w = (a % 64) / 4;
        if (m_lock == 1 || c >= NCH) return;
        if (w >= 8) m_data[c][w-8] = d;
        else if (w == 0) begin
            if (b == 0) begin m_src[c] = 0; m_st[c] = 0; end
            else if (m_st[c] == 0) begin m_src[c] = b; m_st[c] = 1; end
        end
        else if (w == 1) m_dst[c] = b;
        else if (w == 2) begin
            m_pend[c] = m_pend[c] & ~b;
            if (m_st[c] == 2) m_st[c] = 3;
        end
        else if (w == 4) m_auto[c] = d & 1;
        else if (w == 5) m_mask[c] = b;
        else if (w == 6) begin
            if (m_st[c] == 3 && b == m_src[c]) m_st[c] = 1;
        end
        else if (w == 7) begin
            if (m_st[c] == 1 && b == m_src[c]) begin
                m_pend[c] = m_pend[c] | (m_dst[c] & ~m_mask[c] & 'hFF);
                m_st[c] = (m_auto[c] != 0) ? 3 : 2;
            end
        end
    endtask

    function automatic int mdl_read(int a);
        int c, w;
        if (a == 'hA00) return m_lock;
        c = a / 64; w = (a % 64) / 4;
        if (c >= NCH) return 0;
        if (w >= 8) return m_data[c][w-8];
        case (w)
            0: return m_src[c];
            1: return m_dst[c];
            3: return m_pend[c];
            4: return ((m_st[c] == 3) << 7) | ((m_st[c] == 2) << 6) |
                      ((m_st[c] == 1) << 5) | ((m_st[c] == 0) << 4) | m_auto[c];
            5: return m_mask[c];
            default: return 0;
        endcase
    endfunction

    function automatic int mdl_irq(bit want_ack);
        int v = 0;
        for (int c = 0; c < NCH; c++) begin
            if (want_ack) begin if (m_st[c] == 3) v |= m_src[c]; end
            else v |= m_pend[c];
        end
        return v;
    endfunction

    // compare interrupt outputs on every clock, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            n_chk++;
            if (int'(irq_dst) != mdl_irq(0)) begin
                n_fail++;
                $display("FAIL R7 irq_dst actual=%0h expected=%0h", irq_dst, mdl_irq(0));
            end
            n_chk++;
            if (int'(irq_ack) != mdl_irq(1)) begin
                n_fail++;
                $display("FAIL R11 irq_ack actual=%0h expected=%0h", irq_ack, mdl_irq(1));
            end
        end
    end

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr_en = 1;
        @(posedge clk);
        #1 mdl_write(a, d);
        wr_en = 0;
    endtask

    task automatic rd(int a, string tag);
        @(negedge clk);
        addr = AW'(a); wr_en = 0;
        #1;
        n_chk++;
        if (int'(rdata) != mdl_read(a)) begin
            n_fail++;
            $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, rdata, mdl_read(a));
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        mdl_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        running = 1;
        // R1 reset state
        rd('hA00, "R1 lock");
        rd('h010, "R1 mode ch0");
        rd('h0D0, "R1 mode ch3");
        // R3 locked writes ignored
        wr('h000, 1);
        rd('h000, "R3 src locked");
        // R2 wrong key, then key
        wr('hA00, 32'h12345678);
        rd('hA00, "R2 wrong key");
        wr('hA00, KEY);
        rd('hA00, "R2 key opens");
        // R4 claim and re-claim
        wr('h000, 'h01);
        rd('h000, "R4 claim");
        rd('h010, "R12 ready mode");
        wr('h000, 'h02);
        rd('h000, "R4 reclaim ignored");
        // R6 data words
        for (int w = 0; w < 8; w++) wr('h020 + 4*w, 32'hA5000000 + w * 32'h01010101);
        for (int w = 0; w < 8; w++) rd('h020 + 4*w, "R6 data");
        rd('h300, "R6 out of range");
        // R7 manual send with mask
        wr('h004, 'h0C);
        wr('h014, 'hFB);
        wr('h010, 0);
        wr('h01C, 'h02);
        rd('h010, "R7 wrong send bit");
        wr('h01C, 'h01);
        rd('h010, "R9 sent mode");
        rd('h00C, "R10 status");
        wr('h008, 'h04);
        rd('h00C, "R10 cleared");
        rd('h010, "R9 ack after clear");
        wr('h018, 'h02);
        rd('h010, "R11 wrong clear bit");
        wr('h018, 'h01);
        rd('h010, "R11 back to ready");
        // R8 automatic acknowledge
        wr('h010, 1);
        wr('h01C, 'h01);
        rd('h010, "R8 auto ack");
        rd('h00C, "R8 pending");
        wr('h008, 'h04);
        wr('h018, 'h01);
        rd('h010, "R11 ready auto");
        // R3 relock, release ignored
        wr('hA00, 0);
        wr('h000, 0);
        rd('h000, "R3 release ignored");
        rd('hA00, "R2 relocked");
        // R5 release
        wr('hA00, KEY);
        wr('h000, 0);
        rd('h010, "R5 idle again");
        rd('h000, "R5 src cleared");
        // second channel independent
        wr('h0C0, 'h80);
        rd('h0C0, "R4 ch3 claim");
        wr('h0C4, 'h01);
        wr('h0D4, 'h00);
        wr('h0DC, 'h80);
        rd('h0CC, "R7 ch3 pending");
        rd('h0D0, "R9 ch3 sent");
        repeat (2) @(posedge clk);
        running = 0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule